// File: doc/BRIEF.md
# Step-Wise Division Unit

This block divides a 32-bit dividend by a 32-bit divisor when an external driver, such as a sequencer or a testbench, issues a chain of single-cycle commands. Each command is one of these: a signed or unsigned setup, one iteration step, or one of three signed correction steps. The block does not sequence itself. The driver must issue the commands in the required order. The block keeps the partial remainder and the quotient in a high and a low register between commands. It also keeps two sign bits that the setup records.

For an unsigned division the driver issues one unsigned setup and then exactly 32 steps. For a signed division it issues one signed setup, 32 steps, and then the three corrections in the order A, B, C. After the last command the quotient is in the low register and the remainder is in the high register. A signed result truncates toward zero, and its remainder takes the sign of the dividend. The steps and correction A update a zero flag and a carry flag. No other command touches them. If a setup sees a zero divisor, it pulses an error output and leaves all state as it was.

Top module: `stepdiv`

## Requirements
- R1: While reset is held and on the first cycle after it, `rem_o`, `quo_o`, `flag_z`, `flag_c` and `div_err` are all zero.
- R2: Unsigned setup (cmd 1) with a nonzero divisor loads `quo_o` with the dividend and clears `rem_o`, visible one cycle after the command.
- R3: Signed setup (cmd 0) with a nonzero divisor loads `quo_o` with the magnitude of the dividend (two's complement) and clears `rem_o`.
- R4: A step (cmd 2) shifts {rem,quo} left by one bit and subtracts the divisor magnitude from the high part when the shifted value is not smaller than it. The quotient bit goes into bit 0 of `quo_o`, `flag_c` takes that quotient bit, and `flag_z` is set when the new `rem_o` is zero.
- R5: Unsigned setup followed by 32 steps leaves `quo_o` equal to dividend/divisor and `rem_o` equal to dividend%divisor.
- R6: Correction A (cmd 3) keeps `rem_o` and `quo_o`. It sets `flag_z` to (rem_o==0) and sets `flag_c` to the recorded sign bit of the dividend.
- R7: Correction B (cmd 4) negates `quo_o` when the signs of the dividend and the divisor recorded at setup differ. Otherwise it keeps `quo_o`.
- R8: Correction C (cmd 5) negates `rem_o` when the recorded dividend was negative.
- R9: The full signed chain gives the quotient truncated toward zero and a remainder with the dividend's sign. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R10: A setup with a zero divisor pulses `div_err` high for exactly one cycle, and leaves `rem_o`, `quo_o` and the flags unchanged.
- R11: Setup and corrections B and C leave `flag_z` and `flag_c` unchanged.
- R12: With `cmd_valid` low, or with cmd 6 or 7, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code (0 signed setup, 1 unsigned setup, 2 step, 3/4/5 corrections A/B/C) |
| dividend | input | 32 | Dividend, sampled by a setup |
| divisor | input | 32 | Divisor, sampled by a setup |
| rem_o | output | 32 | High register: partial remainder, then the final remainder |
| quo_o | output | 32 | Low register: dividend bits, then the quotient |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| div_err | output | 1 | One-cycle pulse on a setup with a zero divisor |

## Verification
Every command takes exactly one cycle. Its effect on the registers, the flags and `div_err` is due on the first rising edge after the cycle in which the command is presented. The bench changes its inputs on the falling edge and samples outputs on the next falling edge. So each check reads the state exactly one edge after its command, and it also re-reads the outputs one cycle later to confirm that the `div_err` pulse has ended and that held values have not moved. The full-division checks sample only after the last command of each chain.

// File: rtl/stepdiv.sv
module stepdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o,
  output logic         flag_z,
  output logic         flag_c,
  output logic         div_err
);
  localparam logic [2:0] C_SETS = 3'd0, C_SETU = 3'd1, C_STEP = 3'd2,
                         C_FIXA = 3'd3, C_FIXB = 3'd4, C_FIXC = 3'd5;

  logic [W-1:0] hi_q, lo_q, dv_q;
  logic neg_dvd_q, neg_mix_q, fz_q, fc_q, err_q;

  wire [W:0]   part    = {hi_q, lo_q[W-1]};
  wire         take    = part >= {1'b0, dv_q};
  wire [W:0]   diff    = part - {1'b0, dv_q};
  wire [W-1:0] hi_step = take ? diff[W-1:0] : part[W-1:0];

  wire is_setup = cmd_valid && (cmd == C_SETS || cmd == C_SETU);
  wire sgn      = (cmd == C_SETS);
  wire zero_div = (divisor == '0);
  wire [W-1:0] mag_a = (sgn && dividend[W-1]) ? -dividend : dividend;
  wire [W-1:0] mag_b = (sgn && divisor[W-1])  ? -divisor  : divisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; dv_q <= '0;
      neg_dvd_q <= 1'b0; neg_mix_q <= 1'b0;
      fz_q <= 1'b0; fc_q <= 1'b0; err_q <= 1'b0;
    end else begin
      err_q <= is_setup && zero_div;
      if (cmd_valid) begin
        case (cmd)
          C_SETS, C_SETU:
            if (!zero_div) begin
              hi_q      <= '0;
              lo_q      <= mag_a;
              dv_q      <= mag_b;
              neg_dvd_q <= sgn && dividend[W-1];
              neg_mix_q <= sgn && (dividend[W-1] ^ divisor[W-1]);
            end
          C_STEP: begin
            hi_q <= hi_step;
            lo_q <= {lo_q[W-2:0], take};
            fz_q <= (hi_step == '0);
            fc_q <= take;
          end
          C_FIXA: begin
            fz_q <= (hi_q == '0);
            fc_q <= neg_dvd_q;
          end
          C_FIXB: if (neg_mix_q) lo_q <= -lo_q;
          C_FIXC: if (neg_dvd_q) hi_q <= -hi_q;
          default: ;
        endcase
      end
    end
  end

  assign rem_o   = hi_q;
  assign quo_o   = lo_q;
  assign flag_z  = fz_q;
  assign flag_c  = fc_q;
  assign div_err = err_q;

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd == C_SETS || cmd == C_SETU || cmd == C_FIXB || cmd == C_FIXC)
    |=> $stable(flag_z) && $stable(flag_c)); // R11

  AST_ZERO_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_setup && zero_div |=> div_err && $stable(rem_o) && $stable(quo_o)); // R10

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> !div_err || $past(is_setup)); // R10

  AST_STEP_C_IS_QBIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == C_STEP |=> flag_c == quo_o[0]); // R4

  AST_FIXA_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == C_FIXA |=> $stable(rem_o) && $stable(quo_o)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid || cmd[2:1] == 2'b11
    |=> $stable(rem_o) && $stable(quo_o) && $stable(flag_z) && $stable(flag_c)); // R12
endmodule

// File: tb/test_stepdiv.sv
`timescale 1ns/1ps
module test_stepdiv;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd7;
  logic [31:0] dividend = '0, divisor = '0;
  logic [31:0] rem_o, quo_o;
  logic flag_z, flag_c, div_err;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stepdiv i_stepdiv (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .dividend(dividend), .divisor(divisor), .rem_o(rem_o), .quo_o(quo_o),
    .flag_z(flag_z), .flag_c(flag_c), .div_err(div_err));

  localparam int NV = 12;
  // {signed, dividend, divisor}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFFFFFF,   32'd1},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},
    {1'b0, 32'd5,          32'd9},
    {1'b0, 32'hDEADBEEF,   32'h00012345},
    {1'b0, 32'h80000000,   32'h80000001},
    {1'b1, 32'hFFFFFFF9,   32'd2},
    {1'b1, 32'd7,          32'hFFFFFFFE},
    {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9},
    {1'b1, 32'h80000000,   32'hFFFFFFFF},
    {1'b1, 32'd12345678,   32'd1000},
    {1'b1, 32'hFFFFFFF6,   32'd5}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [31:0] a, logic [31:0] b);
    cmd_valid = 1'b1; cmd = c; dividend = a; divisor = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd7;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] eq, er, mq, mr, ma, mb;
    logic sg, na, nb;
    repeat (3) @(negedge clk);
    check("R1 rem", rem_o, 0); check("R1 quo", quo_o, 0);
    check("R1 flags", {29'd0, flag_z, flag_c, div_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rem_o[0], quo_o[0], flag_z, flag_c, div_err}, 0);

    for (int i = 0; i < NV; i++) begin
      sg = VEC[i][64];
      na = sg && VEC[i][63]; nb = sg && VEC[i][31];
      ma = na ? -VEC[i][63:32] : VEC[i][63:32];
      mb = nb ? -VEC[i][31:0] : VEC[i][31:0];
      mq = ma / mb; mr = ma % mb;
      eq = (na ^ nb) ? -mq : mq;
      er = na ? -mr : mr;
      issue(sg ? 3'd0 : 3'd1, VEC[i][63:32], VEC[i][31:0]);
      check(sg ? "R3 setup quo" : "R2 setup quo", quo_o, ma);
      check(sg ? "R3 setup rem" : "R2 setup rem", rem_o, 0);
      for (int s = 0; s < 32; s++) issue(3'd2, 0, 0);
      check("R4 last C", {31'd0, flag_c}, {31'd0, mq[0]});
      check("R4 last Z", {31'd0, flag_z}, {31'd0, mr == 0});
      if (!sg) begin
        check("R5 quotient", quo_o, eq);
        check("R5 remainder", rem_o, er);
      end else begin
        issue(3'd3, 0, 0);
        check("R6 Z", {31'd0, flag_z}, {31'd0, mr == 0});
        check("R6 C", {31'd0, flag_c}, {31'd0, na});
        check("R6 data", quo_o, mq);
        issue(3'd4, 0, 0);
        check("R7 quo", quo_o, eq);
        issue(3'd5, 0, 0);
        check("R8 rem", rem_o, er);
        check("R11 flags", {30'd0, flag_z, flag_c}, {30'd0, mr == 0, na});
        check("R9 quotient", quo_o, eq);
        check("R9 remainder", rem_o, er);
      end
    end

    // R9 overflow corner explicitly
    issue(3'd0, 32'h80000000, 32'hFFFFFFFF);
    for (int s = 0; s < 32; s++) issue(3'd2, 0, 0);
    issue(3'd3, 0, 0); issue(3'd4, 0, 0); issue(3'd5, 0, 0);
    check("R9 min/-1 quo", quo_o, 32'h80000000);
    check("R9 min/-1 rem", rem_o, 0);

    // R4 single step
    issue(3'd1, 32'h80000000, 32'd1);
    issue(3'd2, 0, 0);
    check("R4 step quo", quo_o, 32'd1);
    check("R4 step rem", rem_o, 0);
    check("R4 step flags", {30'd0, flag_z, flag_c}, 2'b11);
    issue(3'd1, 32'h40000000, 32'd3);
    issue(3'd2, 0, 0);
    check("R4 no-take", {quo_o, rem_o[1:0], flag_c, flag_z}, {32'h80000000, 2'd0, 1'b0, 1'b1});

    // R11 setup keeps flags (flags now Z=1 C=0)
    issue(3'd0, 32'hFFFFFFF9, 32'd3);
    check("R3 signed magnitude", quo_o, 32'd7);
    check("R11 setup flags", {30'd0, flag_z, flag_c}, 2'b10);

    // R10 zero divisor
    issue(3'd1, 32'h12345678, 32'd0);
    check("R10 err pulse", {31'd0, div_err}, 1);
    check("R10 quo kept", quo_o, 32'd7);
    check("R10 rem kept", rem_o, 0);
    @(negedge clk);
    check("R10 err ends", {31'd0, div_err}, 0);
    issue(3'd0, 32'd9, 32'd0);
    check("R10 signed err", {31'd0, div_err}, 1);
    check("R10 signed kept", quo_o, 32'd7);

    // R12 ignored commands
    issue(3'd6, 32'd1, 32'd1);
    check("R12 code6", quo_o, 32'd7);
    issue(3'd7, 32'd1, 32'd1);
    check("R12 code7", {quo_o, rem_o}, {32'd7, 32'd0});
    cmd_valid = 1'b0; cmd = 3'd2;
    @(negedge clk);
    cmd = 3'd7;
    check("R12 invalid step", {quo_o, rem_o}, {32'd7, 32'd0});
    check("R12 flags", {30'd0, flag_z, flag_c}, 2'b10);

    // R7 / R8 no-op when signs positive
    issue(3'd0, 32'd9, 32'd4);
    for (int s = 0; s < 32; s++) issue(3'd2, 0, 0);
    issue(3'd4, 0, 0); issue(3'd5, 0, 0);
    check("R7 positive quo", quo_o, 32'd2);
    check("R8 positive rem", rem_o, 32'd1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule